// File: doc/BRIEF.md
# RMS and Power Averaging Engine

This block turns a stream of signed, already calibrated voltage and current samples into metering results. Each accepted sample pair is multiplied at once, and the block outputs that product as the instantaneous power. The block also folds each pair into three running sums: voltage squared, current squared and the voltage-current product. A programmable window length sets how many samples form one computational cycle. When the window closes, the block hands the three sums to sequential dividers. The two mean squares then go through sequential square-root units. All windowed results are then published together, and a one-cycle strobe marks them.

Active power is the signed mean of the products. The two RMS values are the integer square roots of the mean squares. Apparent power is the product of the two RMS values, so every windowed result comes from the same window of samples. A new window starts accumulating while the previous one is still being divided and rooted. The caller must space its samples far enough apart that this post-processing finishes before the next window closes.

Top module: `rms_power_engine`

## Requirements
- R1: The cycle after a sample is accepted (`smp_valid_i` high at a rising edge), `p_inst_o` holds the signed product of that voltage sample and that current sample.
- R2: `p_act_o` is the sum of the window's voltage-current products divided by the number of samples in the window, truncated toward zero, as a signed value.
- R3: `v_rms_o` is the floor of the square root of (sum of squared voltage samples divided by the sample count, rounded down).
- R4: `i_rms_o` is computed by the same rule as R3, applied to the current samples.
- R5: `s_app_o` equals `v_rms_o` times `i_rms_o` and is published together with them.
- R6: A window closes on the accepted sample that brings its count to `win_len_i`. A value of 0 is taken as a window of one sample. The four windowed results change only in the cycle in which `done_o` is high, and exactly once per window.
- R7: `done_o` is high for exactly one cycle per published window.
- R8: The accumulators and quotients do not overflow for any window of up to 2^CNT_W-1 samples, including full-scale negative samples.
- R9: A synchronous reset (`rst` high) clears the running sums, the sample count, `p_inst_o`, all windowed results and `done_o`. Samples taken before the reset do not count toward the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Accepts one voltage/current sample pair |
| v_smp_i | input | SAMPLE_W | Signed voltage sample |
| i_smp_i | input | SAMPLE_W | Signed current sample |
| win_len_i | input | CNT_W | Samples per window (0 acts as 1) |
| p_inst_o | output | 2*SAMPLE_W | Signed instantaneous power of the last sample |
| p_act_o | output | 2*SAMPLE_W | Signed active power of the last window |
| v_rms_o | output | SAMPLE_W | Voltage RMS of the last window |
| i_rms_o | output | SAMPLE_W | Current RMS of the last window |
| s_app_o | output | 2*SAMPLE_W | Apparent power of the last window |
| done_o | output | 1 | One-cycle strobe: new windowed results valid |

## Verification
Every cycle, the assertions check the following. Each division leaves a remainder below the divisor and rebuilds its dividend exactly. Each root is the floor root of its radicand. No accumulator step moves against the sign of its addend. No quotient spills above the mean width. The results move only under `done_o`, and that strobe never lasts two cycles. A window never closes while the previous one is still in flight. Only the bench's scenarios can show the end-to-end values against independently computed sums: the truncation toward zero of negative active power, windows of length 0, 1 and the maximum, full-scale negative inputs, and the dropping of a partial window by a reset.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIV  = 2'd1,
    PH_ROOT = 2'd2
  } phase_t;
endpackage

// File: rtl/rpe_lane_acc.sv
module rpe_lane_acc #(
  parameter int PW = 48,
  parameter int AW = 60
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 add_i,
  input  logic                 clear_i,
  input  logic signed [PW-1:0] prod_i,
  output logic signed [AW-1:0] total_o
);
  logic signed [AW-1:0] acc;

  assign total_o = acc + AW'(prod_i);

  always_ff @(posedge clk) begin
    if (rst)        acc <= '0;
    else if (add_i) acc <= clear_i ? '0 : total_o;
  end

  // R8: a step never wraps against the sign of the addend
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (add_i && !clear_i) |=>
      (($past(prod_i) >= 0) ? (acc >= $past(acc)) : (acc < $past(acc))));
endmodule

// File: rtl/rpe_divider.sv
module rpe_divider #(
  parameter int DW = 60,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] q;
  logic [VW:0]   r;
  logic [VW-1:0] d;
  logic [CW-1:0] k;
  logic          busy;
  logic [DW-1:0] dvd_chk;
  logic [VW:0]   r_sh;
  logic          fits;

  always_comb begin
    r_sh = {r[VW-1:0], q[DW-1]};
    fits = (r_sh >= {1'b0, d});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0; r <= '0; d <= '0; k <= '0;
      busy <= 1'b0; done_o <= 1'b0; dvd_chk <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        q <= dividend_i; r <= '0; d <= divisor_i; k <= '0;
        busy <= 1'b1; dvd_chk <= dividend_i;
      end else if (busy) begin
        q <= {q[DW-2:0], fits};
        r <= fits ? (r_sh - {1'b0, d}) : r_sh;
        k <= k + 1'b1;
        if (k == CW'(DW - 1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = q;

  // R2: quotient and remainder rebuild the dividend exactly
  a_r2_div_exact: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((DW+VW)'(q) * (DW+VW)'(d) + (DW+VW)'(r) == (DW+VW)'(dvd_chk)));
  // R2: remainder stays below the divisor
  a_r2_div_rem: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (r < {1'b0, d}));
endmodule

// File: rtl/rpe_isqrt.sv
module rpe_isqrt #(
  parameter int RW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [2*RW-1:0] rad_i,
  output logic            done_o,
  output logic [RW-1:0]   root_o
);
  localparam int CW = $clog2(RW + 1);

  logic [2*RW-1:0] x;
  logic [2*RW-1:0] rad_chk;
  logic [RW+1:0]   rem;
  logic [RW-1:0]   root;
  logic [CW-1:0]   k;
  logic            busy;
  logic [RW+3:0]   rem_sh;
  logic [RW+3:0]   trial;
  logic            fits;

  always_comb begin
    rem_sh = {rem, x[2*RW-1 -: 2]};
    trial  = {2'b00, root, 2'b01};
    fits   = (rem_sh >= trial);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x <= '0; rad_chk <= '0; rem <= '0; root <= '0; k <= '0;
      busy <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        x <= rad_i; rad_chk <= rad_i; rem <= '0; root <= '0; k <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        x    <= {x[2*RW-3:0], 2'b00};
        rem  <= fits ? (RW+2)'(rem_sh - trial) : (RW+2)'(rem_sh);
        root <= {root[RW-2:0], fits};
        k    <= k + 1'b1;
        if (k == CW'(RW - 1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign root_o = root;

  // R3, R4: the result is the floor root of the radicand
  a_r3_root_floor: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (((2*RW+2)'(root) * (2*RW+2)'(root) <= (2*RW+2)'(rad_chk)) &&
                (((2*RW+2)'(root) + 1) * ((2*RW+2)'(root) + 1) > (2*RW+2)'(rad_chk))));
endmodule

// File: rtl/rms_power_engine.sv
module rms_power_engine
  import rpe_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_valid_i,
  input  logic signed [SAMPLE_W-1:0]   v_smp_i,
  input  logic signed [SAMPLE_W-1:0]   i_smp_i,
  input  logic        [CNT_W-1:0]      win_len_i,
  output logic signed [2*SAMPLE_W-1:0] p_inst_o,
  output logic signed [2*SAMPLE_W-1:0] p_act_o,
  output logic        [SAMPLE_W-1:0]   v_rms_o,
  output logic        [SAMPLE_W-1:0]   i_rms_o,
  output logic        [2*SAMPLE_W-1:0] s_app_o,
  output logic                         done_o
);
  localparam int PW    = 2 * SAMPLE_W;
  localparam int ACC_W = PW + CNT_W;
  localparam int LANES = 3;   // 0: v*v, 1: i*i, 2: v*i
  localparam int ROOTS = 2;   // 0: voltage, 1: current

  function automatic logic signed [PW-1:0] mul_s(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b);
    logic signed [PW-1:0] ea, eb;
    ea = PW'(a);
    eb = PW'(b);
    return ea * eb;
  endfunction

  function automatic logic [ACC_W-1:0] mag(input logic signed [ACC_W-1:0] x);
    return x[ACC_W-1] ? ACC_W'(-x) : ACC_W'(x);
  endfunction

  phase_t               st;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     div_n;
  logic                 win_close;
  logic                 pw_neg;
  logic signed [PW-1:0] prod  [LANES];
  logic signed [ACC_W-1:0] total [LANES];
  logic [ACC_W-1:0]     quot  [LANES];
  logic [LANES-1:0]     div_done;
  logic [SAMPLE_W-1:0]  root  [ROOTS];
  logic [ROOTS-1:0]     root_done;
  logic signed [PW-1:0] mean_p;

  assign prod[0] = mul_s(v_smp_i, v_smp_i);
  assign prod[1] = mul_s(i_smp_i, i_smp_i);
  assign prod[2] = mul_s(v_smp_i, i_smp_i);

  assign win_close = smp_valid_i &&
                     (({1'b0, cnt} + (CNT_W+1)'(1)) >= (CNT_W+1)'(win_len_i));
  assign div_n     = cnt + 1'b1;
  assign mean_p    = $signed(quot[2][PW-1:0]);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    rpe_lane_acc #(.PW(PW), .AW(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .add_i(smp_valid_i), .clear_i(win_close),
      .prod_i(prod[l]), .total_o(total[l]));

    rpe_divider #(.DW(ACC_W), .VW(CNT_W)) u_div (
      .clk(clk), .rst(rst), .start_i(win_close),
      .dividend_i(mag(total[l])), .divisor_i(div_n),
      .done_o(div_done[l]), .quot_o(quot[l]));

    // R8: every mean fits in the product width
    a_r8_mean_fits: assert property (@(posedge clk) disable iff (rst)
      div_done[l] |-> (quot[l][ACC_W-1:PW] == '0));
  end

  for (genvar r = 0; r < ROOTS; r++) begin : g_root
    rpe_isqrt #(.RW(SAMPLE_W)) u_root (
      .clk(clk), .rst(rst), .start_i(&div_done),
      .rad_i(quot[r][PW-1:0]), .done_o(root_done[r]), .root_o(root[r]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= PH_IDLE; cnt <= '0; pw_neg <= 1'b0;
      p_inst_o <= '0; p_act_o <= '0; v_rms_o <= '0; i_rms_o <= '0;
      s_app_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (smp_valid_i) begin
        p_inst_o <= prod[2];
        cnt      <= win_close ? '0 : cnt + 1'b1;
      end
      if (win_close) pw_neg <= total[2][ACC_W-1];
      unique case (st)
        PH_IDLE: if (win_close) st <= PH_DIV;
        PH_DIV:  if (&div_done) st <= PH_ROOT;
        PH_ROOT: if (&root_done) begin
          v_rms_o <= root[0];
          i_rms_o <= root[1];
          s_app_o <= PW'(root[0]) * PW'(root[1]);
          p_act_o <= pw_neg ? -mean_p : mean_p;
          done_o  <= 1'b1;
          st      <= PH_IDLE;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  // R6: windowed results move only with the strobe
  a_r6_results_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable({p_act_o, v_rms_o, i_rms_o, s_app_o}) |-> done_o);
  // R6: no window closes while the previous one is in flight
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
    win_close |-> (st == PH_IDLE));
  // R7: strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9: reset clears count, results and strobe
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (cnt == '0 && v_rms_o == '0 && i_rms_o == '0 &&
             p_act_o == '0 && s_app_o == '0 && !done_o));
endmodule

// File: tb/rms_power_engine_test.sv
module rms_power_engine_test;
  localparam int SW  = 8;
  localparam int NW  = 4;
  localparam int GAP = 48;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst, vld;
  logic signed [SW-1:0]   vs, is;
  logic [NW-1:0]          nlen;
  logic signed [2*SW-1:0] p_inst_o, p_act_o;
  logic [SW-1:0]          v_rms_o, i_rms_o;
  logic [2*SW-1:0]        s_app_o;
  logic                   done_o;

  rms_power_engine #(.SAMPLE_W(SW), .CNT_W(NW)) uut (
    .clk(clk), .rst(rst), .smp_valid_i(vld), .v_smp_i(vs), .i_smp_i(is),
    .win_len_i(nlen), .p_inst_o(p_inst_o), .p_act_o(p_act_o),
    .v_rms_o(v_rms_o), .i_rms_o(i_rms_o), .s_app_o(s_app_o), .done_o(done_o));

  int n_chk = 0, n_fail = 0, dones = 0;
  bit finished = 0;
  longint exp_pa = 0, exp_v = 0, exp_i = 0, exp_s = 0;

  always @(negedge clk) if (done_o) dones++;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint x);
    longint r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  task automatic gen(input int mode, input int k, input int seed,
                     output int v, output int i);
    case (mode)
      1: begin v = -128; i = -128; end
      2: begin v = -128; i = 127; end
      3: begin v = 0; i = 0; end
      4: begin v = (k % 2 == 0) ? 100 : -100; i = -50; end
      default: begin
        v = ((k * 37 + seed * 53) % 256) - 128;
        i = ((k * 91 + seed * 29 + 11) % 256) - 128;
      end
    endcase
  endtask

  task automatic send(input int v, input int i);
    @(negedge clk);
    vs = SW'(v); is = SW'(i); vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    check("R1 instantaneous power", p_inst_o, longint'(v) * i);
  endtask

  task automatic run_window(input int n, input int mode, input int seed);
    int cnt = (n == 0) ? 1 : n;
    longint svv = 0, sii = 0, svi = 0;
    int d0 = dones;
    int w = 0;
    nlen = NW'(n);
    for (int k = 0; k < cnt; k++) begin
      int v, i;
      gen(mode, k, seed, v, i);
      send(v, i);
      svv += longint'(v) * v; sii += longint'(i) * i; svi += longint'(v) * i;
      if (k < cnt - 1) begin
        repeat (GAP) @(negedge clk);
        check("R6 results held mid-window", v_rms_o, exp_v);
        check("R6 no strobe mid-window", dones, d0);
      end
    end
    while (!done_o && w < 200) begin @(negedge clk); w++; end
    check("R6 strobe after window", done_o, 1);
    exp_pa = svi / cnt;
    exp_v  = isqrt(svv / cnt);
    exp_i  = isqrt(sii / cnt);
    exp_s  = exp_v * exp_i;
    check("R2 active power", p_act_o, exp_pa);
    check("R3 voltage rms", v_rms_o, exp_v);
    check("R4 current rms", i_rms_o, exp_i);
    check("R5 apparent power", s_app_o, exp_s);
    @(negedge clk);
    check("R7 strobe one cycle", done_o, 0);
    check("R6 one strobe per window", dones - d0, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int d1;
    rst = 1'b1; vld = 1'b0; vs = '0; is = '0; nlen = NW'(4);
    repeat (5) @(negedge clk);
    // R9 reset state
    check("R9 reset p_inst", p_inst_o, 0);
    check("R9 reset active", p_act_o, 0);
    check("R9 reset vrms", v_rms_o, 0);
    check("R9 reset strobe", done_o, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R9: partial window dropped by reset
    send(90, -70);
    repeat (GAP) @(negedge clk);
    send(-40, 33);
    repeat (GAP) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 p_inst cleared", p_inst_o, 0);
    d1 = dones;
    run_window(4, 0, 77);
    check("R9 window restarted", dones - d1, 1);

    // sweep of window lengths, including 0 (one sample) and maximum
    for (int n = 0; n < 16; n++) run_window(n, 0, n + 1);
    for (int n = 13; n < 16; n++) run_window(n, 0, n * 7 + 3);
    // R8 full-scale windows
    run_window(15, 1, 0);
    run_window(15, 2, 0);
    run_window(1, 2, 0);
    run_window(7, 1, 0);
    // R2 negative mean truncated toward zero, then zero input
    run_window(3, 4, 0);
    run_window(4, 4, 0);
    run_window(5, 3, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule